// File: doc/BRIEF.md
# Audio Stream Flow Monitor

This block sits beside an audio sample path and watches three single-cycle event pulses: one per completed frame, one when a frame was lost to a full buffer (overflow) and one when a frame had to be played without fresh data (underflow). It keeps a running count of each event class and two sticky status flags. When interrupt reporting is enabled, it raises an interrupt line while either flag is set.

Software drives it through a small register port. A write to the control/status word sets three enable bits. The same write can also fire two self-clearing strobes: one zeroes the counters and one zeroes the flags. Reads are combinational from a two-bit address: word 0 is the control/status word, word 1 the frame total, word 2 the overflow count and word 3 the underflow count. Counters are `CNT_W` bits wide, zero-extended to 32 bits on reads.

Top module: `afm_flow_monitor`

## Requirements
- R1: After synchronous reset, all three counters read 0, both flags and all enable bits read 0, and `irq` is low.
- R2: In the control/status word (address 0), writes set these bits: bit 0 is the monitor enable, bit 1 the counter enable and bit 4 the interrupt enable. All three read back at the same positions. Bits 2 and 3 are strobes and always read 0.
- R3: While the counter enable is 1, each cycle with `frame_tick` high adds one to the frame total (address 1).
- R4: While the counter enable is 1, each cycle with `ovf_evt` high adds one to the overflow count (address 2), and each cycle with `unf_evt` high adds one to the underflow count (address 3).
- R5: While the counter enable is 0, event pulses leave all three counters unchanged.
- R6: While the monitor enable is 1, an `unf_evt` sets the underflow flag at bit 31 and an `ovf_evt` sets the overflow flag at bit 30. Each flag stays set until it is cleared.
- R7: While the monitor enable is 0, event pulses leave both flags unchanged.
- R8: A write to address 0 with bit 3 set zeroes all three counters at that clock edge. This wins over any increment in the same cycle and leaves the flags alone.
- R9: A write to address 0 with bit 2 set zeroes both flags at that clock edge. This wins over any event in the same cycle and leaves the counters alone.
- R10: A counter that reads all ones (2^CNT_W-1) stays at that value on further events.
- R11: `irq` is high exactly when the interrupt enable is 1 and at least one flag is set.
- R12: An enable bit written in a cycle governs events from the following cycle on. Events in the write cycle itself see the old enable value. Writes to addresses 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One pulse per frame |
| ovf_evt | input | 1 | Overflow event pulse |
| unf_evt | input | 1 | Underflow event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two conditions are hard to reach from the ports: a clear strobe and an event landing in the same cycle, and a counter reaching saturation. The stimulus table fires a monitor clear together with an underflow pulse and a counter clear together with a frame tick, so the priority rules can be seen. The bench builds the block with an 8-bit counter and drives 260 consecutive frame ticks, which pushes the total past all ones. A reference model in the bench, written from the requirements, applies each enable with a one-cycle lag. Every register is compared after every step.

// File: rtl/afm_pkg.sv
`timescale 1ns/1ps
package afm_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int NUM_CNT   = 3;

    localparam int BIT_MON_EN  = 0;
    localparam int BIT_CNT_EN  = 1;
    localparam int BIT_MON_CLR = 2;
    localparam int BIT_CNT_CLR = 3;
    localparam int BIT_IRQ_EN  = 4;
    localparam int BIT_OVF     = 30;
    localparam int BIT_UNF     = 31;

    localparam int IDX_FRAME = 0;
    localparam int IDX_OVF   = 1;
    localparam int IDX_UNF   = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CSR   = 2'd0,
        REG_TOTAL = 2'd1,
        REG_OVF   = 2'd2,
        REG_UNF   = 2'd3
    } afm_reg_e;

    typedef struct packed {
        logic irq_en;
        logic cnt_en;
        logic mon_en;
    } afm_ctrl_t;

    typedef struct packed {
        logic unf;
        logic ovf;
    } afm_flags_t;

    typedef struct packed {
        logic cnt_clr;
        logic mon_clr;
    } afm_strobe_t;

    function automatic logic [DATA_W-1:0] pack_csr(afm_ctrl_t c, afm_flags_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_MON_EN] = c.mon_en;
        w[BIT_CNT_EN] = c.cnt_en;
        w[BIT_IRQ_EN] = c.irq_en;
        w[BIT_OVF]    = f.ovf;
        w[BIT_UNF]    = f.unf;
        return w;
    endfunction
endpackage

// File: rtl/afm_ctrl_regs.sv
`timescale 1ns/1ps
module afm_ctrl_regs
    import afm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output afm_ctrl_t         ctrl_q,
    output afm_strobe_t       strobe
);
    logic csr_wr;

    assign csr_wr = wr_en && (afm_reg_e'(wr_addr) == REG_CSR);

    always_comb begin
        strobe.cnt_clr = csr_wr && wr_data[BIT_CNT_CLR];
        strobe.mon_clr = csr_wr && wr_data[BIT_MON_CLR];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (csr_wr) begin
            ctrl_q.mon_en <= wr_data[BIT_MON_EN];
            ctrl_q.cnt_en <= wr_data[BIT_CNT_EN];
            ctrl_q.irq_en <= wr_data[BIT_IRQ_EN];
        end
    end
endmodule

// File: rtl/afm_counter_bank.sv
`timescale 1ns/1ps
module afm_counter_bank
    import afm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N     = NUM_CNT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    clr,
    input  logic [N-1:0]            ev,
    output logic [N-1:0][CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt_q[i] <= '0;
            end else if (en && ev[i] && (cnt_q[i] != CNT_MAX)) begin
                cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/afm_status_mon.sv
`timescale 1ns/1ps
module afm_status_mon
    import afm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       clr,
    input  logic       irq_en,
    input  logic       ovf_evt,
    input  logic       unf_evt,
    output afm_flags_t flag_q,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag_q <= '0;
        end else if (en) begin
            if (ovf_evt) flag_q.ovf <= 1'b1;
            if (unf_evt) flag_q.unf <= 1'b1;
        end
    end

    assign irq = irq_en && (flag_q.ovf || flag_q.unf);
endmodule

// File: rtl/afm_flow_monitor.sv
`timescale 1ns/1ps
module afm_flow_monitor
    import afm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic              ovf_evt,
    input  logic              unf_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq
);
    afm_ctrl_t                    ctrl_q;
    afm_strobe_t                  strobe;
    afm_flags_t                   flag_q;
    logic [NUM_CNT-1:0]           ev;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_ext;

    always_comb begin
        ev            = '0;
        ev[IDX_FRAME] = frame_tick;
        ev[IDX_OVF]   = ovf_evt;
        ev[IDX_UNF]   = unf_evt;
    end

    afm_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .strobe  (strobe)
    );

    afm_counter_bank #(.CNT_W(CNT_W), .N(NUM_CNT)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl_q.cnt_en),
        .clr   (strobe.cnt_clr),
        .ev    (ev),
        .cnt_q (cnt_q)
    );

    afm_status_mon u_mon (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.mon_en),
        .clr     (strobe.mon_clr),
        .irq_en  (ctrl_q.irq_en),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt),
        .flag_q  (flag_q),
        .irq     (irq)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_ext
        always_comb begin
            cnt_ext[i] = '0;
            cnt_ext[i][CNT_W-1:0] = cnt_q[i];
        end
    end

    always_comb begin
        unique case (afm_reg_e'(rd_addr))
            REG_CSR:   rd_data = pack_csr(ctrl_q, flag_q);
            REG_TOTAL: rd_data = cnt_ext[IDX_FRAME];
            REG_OVF:   rd_data = cnt_ext[IDX_OVF];
            REG_UNF:   rd_data = cnt_ext[IDX_UNF];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/afm_flow_monitor_chk.sv
`timescale 1ns/1ps
module afm_flow_monitor_chk
    import afm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           frame_tick,
    input logic                           irq,
    input afm_ctrl_t                      ctrl_q,
    input afm_strobe_t                    strobe,
    input afm_flags_t                     flag_q,
    input logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        strobe.cnt_clr |=> (cnt_q == '0));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        strobe.mon_clr |=> (flag_q == '0));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.cnt_en && !strobe.cnt_clr) |=> $stable(cnt_q));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.mon_en && !strobe.mon_clr) |=> $stable(flag_q));

    // R3
    total_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cnt_en && frame_tick && !strobe.cnt_clr && cnt_q[IDX_FRAME] != CNT_MAX)
        |=> (cnt_q[IDX_FRAME] == $past(cnt_q[IDX_FRAME]) + 1'b1));

    // R10
    total_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[IDX_FRAME] == CNT_MAX && !strobe.cnt_clr) |=> (cnt_q[IDX_FRAME] == CNT_MAX));

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q.irq_en && (flag_q != '0)));
endmodule

bind afm_flow_monitor afm_flow_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .irq        (irq),
    .ctrl_q     (ctrl_q),
    .strobe     (strobe),
    .flag_q     (flag_q),
    .cnt_q      (cnt_q)
);

// File: tb/sim_afm_flow_monitor.sv
`timescale 1ns/1ps
module sim_afm_flow_monitor;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int NVEC  = 17;

    // vector: {repeat[8], wr, addr[2], data[32], frame, ovf, unf}
    localparam logic [45:0] VEC [NVEC] = '{
        {8'd1,   1'b1, 2'd0, 32'h0000_0003, 3'b000}, // R2 enable mon+cnt
        {8'd3,   1'b0, 2'd0, 32'h0,         3'b100}, // R3 frames
        {8'd2,   1'b0, 2'd0, 32'h0,         3'b110}, // R4 frame+ovf
        {8'd1,   1'b0, 2'd0, 32'h0,         3'b001}, // R4 R6 unf
        {8'd1,   1'b1, 2'd0, 32'h0000_0013, 3'b000}, // R11 irq on
        {8'd1,   1'b1, 2'd0, 32'h0000_0017, 3'b101}, // R9 clear vs unf, frame counts
        {8'd1,   1'b0, 2'd0, 32'h0,         3'b001}, // R6 unf flag again
        {8'd1,   1'b1, 2'd0, 32'h0000_001B, 3'b100}, // R8 clear vs frame
        {8'd1,   1'b1, 2'd0, 32'h0000_0010, 3'b111}, // R12 old enables apply
        {8'd4,   1'b0, 2'd0, 32'h0,         3'b111}, // R5 R7 all disabled
        {8'd1,   1'b1, 2'd0, 32'h0000_0001, 3'b010}, // R12 mon on, event sees old
        {8'd1,   1'b0, 2'd0, 32'h0,         3'b010}, // R6 ovf flag, R5 no count
        {8'd1,   1'b1, 2'd0, 32'h0000_0002, 3'b000}, // R2 cnt only
        {8'd255, 1'b0, 2'd0, 32'h0,         3'b100}, // R10 reach max
        {8'd5,   1'b0, 2'd0, 32'h0,         3'b110}, // R10 stay at max
        {8'd1,   1'b1, 2'd1, 32'hFFFF_FFFF, 3'b000}, // R12 write to counter ignored
        {8'd1,   1'b1, 2'd0, 32'h0000_000E, 3'b000}  // R8 R9 both clears
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_tick = 1'b0, ovf_evt = 1'b0, unf_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit m_mon, m_cnt, m_irq_en, m_ovf, m_unf;
    int m_c [3];

    always #2.5 clk = ~clk;

    afm_flow_monitor #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .ovf_evt(ovf_evt),
        .unf_evt(unf_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic model_reset();
        m_mon = 0; m_cnt = 0; m_irq_en = 0; m_ovf = 0; m_unf = 0;
        for (int i = 0; i < 3; i++) m_c[i] = 0;
    endtask

    task automatic model_step(bit w, logic [1:0] a, logic [31:0] d, bit f, bit o, bit u);
        bit csr;
        bit [2:0] ev;
        csr = w && (a == 2'd0);
        ev = {u, o, f};
        if (csr && d[3]) begin
            for (int i = 0; i < 3; i++) m_c[i] = 0;
        end else if (m_cnt) begin
            for (int i = 0; i < 3; i++)
                if (ev[i] && m_c[i] < CMAX) m_c[i] = m_c[i] + 1;
        end
        if (csr && d[2]) begin
            m_ovf = 0; m_unf = 0;
        end else if (m_mon) begin
            if (o) m_ovf = 1;
            if (u) m_unf = 1;
        end
        if (csr) begin
            m_mon = d[0]; m_cnt = d[1]; m_irq_en = d[4];
        end
    endtask

    task automatic check_word(logic [1:0] a, logic [31:0] exp, string tag);
        rd_addr = a;
        #0.2;
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic check_all(string ctx);
        logic [31:0] csr;
        csr = '0;
        csr[0] = m_mon; csr[1] = m_cnt; csr[4] = m_irq_en;
        csr[30] = m_ovf; csr[31] = m_unf;
        check_word(2'd0, csr, {"R2 R6 R7 R9 ", ctx});
        check_word(2'd1, 32'(m_c[0]), {"R3 R5 R8 R10 ", ctx});
        check_word(2'd2, 32'(m_c[1]), {"R4 R5 R8 ", ctx});
        check_word(2'd3, 32'(m_c[2]), {"R4 R5 R8 ", ctx});
        n_chk++;
        if (irq !== (m_irq_en && (m_ovf || m_unf))) begin
            n_fail++;
            $display("FAIL R11 %s irq: actual %b expected %b", ctx, irq,
                     m_irq_en && (m_ovf || m_unf));
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(bit w, logic [1:0] a, logic [31:0] d, bit f, bit o, bit u, string ctx);
        wr_en = w; wr_addr = a; wr_data = d;
        frame_tick = f; ovf_evt = o; unf_evt = u;
        @(posedge clk);
        model_step(w, a, d, f, o, u);
        @(negedge clk);
        wr_en = 0; wr_addr = '0; wr_data = '0;
        frame_tick = 0; ovf_evt = 0; unf_evt = 0;
        check_all(ctx);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1 reset");

        for (int v = 0; v < NVEC; v++) begin
            for (int r = 0; r < int'(VEC[v][45:38]); r++) begin
                step(VEC[v][37], VEC[v][36:35], VEC[v][34:3],
                     VEC[v][2], VEC[v][1], VEC[v][0], $sformatf("vec%0d", v));
            end
        end

        // directed: fill state, then R1 reset mid-run
        step(1, 2'd0, 32'h0000_0013, 0, 0, 0, "R2 setup");
        step(0, 2'd0, 32'h0, 1, 1, 1, "R3 R4 R6 events");
        step(0, 2'd0, 32'h0, 1, 0, 0, "R3 more");
        rst = 1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 0;
        check_all("R1 mid-run reset");

        // directed: R12 counter enable written with a same-cycle frame does not count it
        step(1, 2'd0, 32'h0000_0002, 1, 0, 0, "R12 enable lag");
        step(0, 2'd0, 32'h0, 1, 0, 0, "R3 after enable");
        // directed: R7 monitor disabled, irq enabled, no flag
        step(1, 2'd0, 32'h0000_0012, 0, 1, 1, "R7 R11 no flags");

        finish_run();
    end
endmodule